// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger and Idle Timeout

This block buffers the bytes that a UART receive shifter assembles until the host reads them. It holds up to sixteen bytes in arrival order. A push strobe from the shifter stores a byte. A pop strobe from the host moves the oldest byte onto the read-data output. The block reports its fill level, empty and full, and a one-cycle overrun pulse when a byte arrives while the queue is full.

Two flags help the host avoid polling. The trigger flag is high while the fill level is at or above a threshold picked by a 3-bit select with a nonlinear mapping. The idle-timeout flag is high when bytes are waiting and nothing has touched the queue for four character frames. The length of that wait follows the programmed word length. Bit-time ticks from the baud generator measure it.

A queue-enable input and a flush input both hold the queue empty while they are active. Neither one affects the shifter that feeds the queue.

Top module: `rxq_top`

## Requirements
- R1: After reset, empty is 1, level is 0, and full, trig_hit, timeout and overrun are 0.
- R2: Bytes come out in the order they were accepted. A pop on a non-empty queue places the oldest byte on rd_data after the clock edge that takes the pop.
- R3: level counts the bytes held, from 0 to 16. full is 1 exactly at 16 and empty is 1 exactly at 0.
- R4: A push while the queue is full and no pop is present is dropped. overrun is then 1 for the following cycle only, and level stays unchanged.
- R5: A pop on an empty queue leaves rd_data and level unchanged.
- R6: trig_sel value 0 selects a threshold of 1 byte. Any other value k selects 2·k bytes, so the thresholds are 1, 2, 4, 6, 8, 10, 12 and 14. trig_hit is 1 exactly when level is at least the threshold.
- R7: word_len value w (0..3) stands for 5+w data bits. The idle limit is 4·(8+w) bit ticks, giving 32, 36, 40 and 44. timeout becomes 1 after that many bit_tick cycles with no push and no pop while the queue holds data, and not one tick earlier.
- R8: timeout is never 1 while the queue is empty.
- R9: A push, a pop or a flush restarts the idle count, so timeout is 0 in the cycle after any of them.
- R10: While flush_req is 1 the queue is empty and pushes are ignored. Normal operation resumes once flush_req returns to 0.
- R11: While fifo_en is 0 the queue is held empty and pushes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Queue enable; 0 holds the queue empty |
| flush_req | input | 1 | Flush; holds the queue empty while 1 |
| trig_sel | input | 3 | Trigger threshold select |
| word_len | input | 2 | Data-bit count select (5+value bits) |
| bit_tick | input | 1 | One pulse per serial bit time |
| push | input | 1 | Store push_data |
| push_data | input | 8 | Byte from the receive shifter |
| pop | input | 1 | Host read of the oldest byte |
| rd_data | output | 8 | Last byte popped |
| level | output | 5 | Number of bytes held |
| empty | output | 1 | Level is 0 |
| full | output | 1 | Level is 16 |
| trig_hit | output | 1 | Level at or above the selected threshold |
| timeout | output | 1 | Data has been left unread for the idle limit |
| overrun | output | 1 | One-cycle pulse for a dropped push |

## Verification
The ordering check runs a short burst and a full sixteen-byte burst, each with distinct byte values. An off-by-one pointer or a lost wrap therefore shows up as a wrong byte, not a wrong count. The trigger mapping is swept over every select code at every fill level from 0 to 14, which separates a linear mapping from the real one and a greater-than compare from a greater-or-equal one. The idle timer is stopped one tick short of and exactly at the limit, for the shortest and the longest word length. It is then cleared in turn by a pop, a push and a flush, which separates a fixed limit from a scaled one and shows which clear events are handled.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Trigger threshold: code 0 means one byte, code k means 2k bytes.
  function automatic logic [4:0] trig_threshold(input logic [2:0] sel);
    if (sel == 3'd0) return 5'd1;
    return {1'b0, sel, 1'b0};
  endfunction

  // Idle limit: four frames of start + (5+wl) data + parity + stop bits.
  function automatic logic [5:0] idle_limit(input logic [1:0] wl);
    logic [5:0] frame_bits;
    frame_bits = 6'd8 + {4'b0000, wl};
    return frame_bits << 2;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_data <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) begin
        rd_ptr  <= bump(rd_ptr);
        rd_data <= mem[rd_ptr];
      end
      count <= count + LW'(wr_en) - LW'(rd_en);
    end
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          has_data,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        idle_cnt <= '0;
    else if (restart || !has_data)     idle_cnt <= '0;
    else if (tick && idle_cnt < limit) idle_cnt <= idle_cnt + 1'b1;
  end

  assign expired = has_data && (idle_cnt >= limit);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          flush_req,
  input  logic [2:0]    trig_sel,
  input  logic [1:0]    word_len,
  input  logic          bit_tick,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          trig_hit,
  output logic          timeout,
  output logic          overrun
);
  // Named internal events
  logic hold_clr, push_ok, pop_ok, push_drop, access;

  assign hold_clr  = !fifo_en || flush_req;
  assign empty     = (level == '0);
  assign full      = (level == LW'(DEPTH));
  assign pop_ok    = pop && !hold_clr && !empty;
  assign push_ok   = push && !hold_clr && (!full || pop_ok);
  assign push_drop = push && !hold_clr && full && !pop_ok;
  assign access    = push || pop || hold_clr;

  rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr),
    .wr_en(push_ok), .wr_data(push_data),
    .rd_en(pop_ok), .rd_data(rd_data), .count(level)
  );

  rxq_idle_timer #(.CW(6)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(access), .has_data(!empty),
    .tick(bit_tick), .limit(idle_limit(word_len)), .expired(timeout)
  );

  assign trig_hit = int'(level) >= int'(trig_threshold(trig_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else        overrun <= push_drop;
  end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          flush_req,
  input logic          push,
  input logic          pop,
  input logic [W-1:0]  rd_data,
  input logic [LW-1:0] level,
  input logic          empty,
  input logic          full,
  input logic          trig_hit,
  input logic          timeout,
  input logic          overrun
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  assert_not_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_overrun_keeps_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(full) && level == $past(level)));

  assert_empty_pop_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> ($stable(rd_data) && empty));

  assert_trig_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> !empty);

  assert_timeout_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !empty);

  assert_timeout_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push || pop || flush_req) |=> !timeout);

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> empty);

  assert_disable_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> empty);
endmodule

bind rxq_top rxq_checker #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush_req(flush_req),
  .push(push), .pop(pop), .rd_data(rd_data), .level(level),
  .empty(empty), .full(full), .trig_hit(trig_hit), .timeout(timeout),
  .overrun(overrun)
);

// File: tb/rxq_top_tb.sv
module rxq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1, flush_req = 1'b0;
  logic [2:0] trig_sel = 3'd0;
  logic [1:0] word_len = 2'd0;
  logic       bit_tick = 1'b0, push = 1'b0, pop = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic       empty, full, trig_hit, timeout, overrun;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_rd = 8'h00;

  always #5 clk = ~clk;

  rxq_top u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush_req(flush_req),
    .trig_sel(trig_sel), .word_len(word_len), .bit_tick(bit_tick),
    .push(push), .push_data(push_data), .pop(pop), .rd_data(rd_data),
    .level(level), .empty(empty), .full(full), .trig_hit(trig_hit),
    .timeout(timeout), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Driver: offers a byte and records it in the scoreboard if it fits.
  task automatic push_byte(input logic [7:0] b);
    push = 1'b1; push_data = b;
    if (fifo_en && !flush_req && exp_q.size() < 16) exp_q.push_back(b);
    step();
    push = 1'b0;
  endtask

  // Monitor: one pop, then compare with the scoreboard head.
  task automatic pop_byte(input string req);
    pop = 1'b1;
    step();
    pop = 1'b0;
    if (exp_q.size() > 0) last_rd = exp_q.pop_front();
    check(req, int'(rd_data), int'(last_rd));
  endtask

  task automatic ticks(input int n);
    bit_tick = 1'b1;
    repeat (n) step();
    bit_tick = 1'b0;
  endtask

  function automatic int thr(input int sel);
    return (sel == 0) ? 1 : sel * 2;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 empty", empty, 1);
    check("R1 level", level, 0);
    check("R1 full", full, 0);
    check("R1 trig_hit", trig_hit, 0);
    check("R1 timeout", timeout, 0);
    check("R1 overrun", overrun, 0);

    // R6 and R2 with a short burst, threshold 6
    trig_sel = 3'd3;
    for (int i = 0; i < 5; i++) push_byte(8'h10 + 8'(i));
    check("R6 below six", trig_hit, 0);
    push_byte(8'h15);
    check("R6 at six", trig_hit, 1);
    check("R3 level six", level, 6);
    pop_byte("R2 first out");
    check("R6 back below", trig_hit, 0);
    for (int i = 0; i < 5; i++) pop_byte("R2 order short");
    check("R3 empty again", empty, 1);

    // R5 pop on empty
    pop = 1'b1; step(); pop = 1'b0;
    check("R5 rd_data kept", rd_data, 8'h15);
    check("R5 level kept", level, 0);

    // R3 / R4 full and overrun
    for (int i = 0; i < 16; i++) push_byte(8'hA0 + 8'(i * 3));
    check("R3 full", full, 1);
    check("R3 level 16", level, 16);
    push = 1'b1; push_data = 8'hEE; step(); push = 1'b0;
    check("R4 overrun pulse", overrun, 1);
    check("R4 level kept", level, 16);
    step();
    check("R4 pulse one cycle", overrun, 0);
    for (int i = 0; i < 16; i++) pop_byte("R2 order full");
    check("R4 dropped byte absent", empty, 1);

    // R10 flush
    for (int i = 0; i < 4; i++) push_byte(8'h30 + 8'(i));
    flush_req = 1'b1; step();
    check("R10 flush empties", empty, 1);
    exp_q.delete();
    push_byte(8'h77);
    check("R10 push ignored", level, 0);
    flush_req = 1'b0; step();
    push_byte(8'h5A);
    pop_byte("R10 resumes");

    // R6 full sweep
    for (int lv = 0; lv <= 14; lv++) begin
      for (int s = 0; s < 8; s++) begin
        trig_sel = 3'(s); #1;
        check("R6 sweep", trig_hit, (lv >= thr(s)) ? 1 : 0);
      end
      if (lv < 14) push_byte(8'(lv));
    end
    flush_req = 1'b1; step(); flush_req = 1'b0; exp_q.delete(); step();

    // R7 / R8 / R9 idle timeout
    word_len = 2'd0;
    push_byte(8'hC1);
    ticks(31);
    check("R7 wl0 one short", timeout, 0);
    ticks(1);
    check("R7 wl0 at limit", timeout, 1);
    pop_byte("R2 timeout byte");
    check("R9 pop clears", timeout, 0);
    ticks(50);
    check("R8 empty no timeout", timeout, 0);
    word_len = 2'd3;
    push_byte(8'hC2);
    ticks(43);
    check("R7 wl3 one short", timeout, 0);
    ticks(1);
    check("R7 wl3 at limit", timeout, 1);
    push_byte(8'hC3);
    check("R9 push clears", timeout, 0);
    check("R3 level two", level, 2);
    ticks(44);
    check("R7 wl3 again", timeout, 1);
    flush_req = 1'b1; step();
    check("R9 flush clears", timeout, 0);
    flush_req = 1'b0; exp_q.delete(); step();

    // R11 disabled queue
    fifo_en = 1'b0; step();
    push_byte(8'h99);
    check("R11 push ignored", level, 0);
    check("R11 empty", empty, 1);
    fifo_en = 1'b1; step();
    push_byte(8'h42);
    pop_byte("R11 resumes");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule